// File: doc/BRIEF.md
# Demodulated Data Edge Debouncer

This block cleans up the raw bit stream coming out of an amplitude demodulator before a microcontroller sees it. The raw input is asynchronous to the system clock and may carry short noise spikes. The block first resynchronises it. It then looks at the synchronised level only when a strobe marks the end of an extended tick. The output line can therefore move only on the tick grid, so the time between any two output edges is a whole number of ticks.

After each output edge a hold window of ten ticks starts. No further edge is allowed until the window has run out. A glitch on the input that is gone before the window closes leaves no trace on the output. The output edge rate is bounded, which limits how often the microcontroller is interrupted. The tick period is set outside the block according to the baud range in use, so the minimum spacing in time grows and shrinks with it.

A forwarding enable gates the whole path. While it is low the output is held at the idle high level and any running hold window is dropped.

Top module: `demod_edge_guard`

## Requirements
- R1: After reset is released the output `data_o` is high, and no hold window is running.
- R2: `data_o` changes only at a clock edge where `tick_i` was high, or when forwarding is disabled. Every interval between output edges is therefore a whole number of ticks.
- R3: Two consecutive output edges produced while forwarding stays enabled are at least 10 ticks apart. The tick that carries an edge counts as tick 0, and the next edge may fall on tick 10 at the earliest.
- R4: When no hold window is running, `data_o` takes the synchronised input level at the first tick where the two differ. The raw input passes through two clock stages first. A level applied to `raw_i` before clock edge k is acted on at edge k+2 when `tick_i` is high there, so `data_o` shows it after edge k+2.
- R5: An input excursion that has returned to the current output level by the time the hold window expires produces no output edge.
- R6: While `fwd_en_i` is low, `data_o` is high one clock later and stays high. The hold window is cleared, so the first mismatch after forwarding is re-enabled is acted on at its first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock strobe marking each extended tick |
| raw_i | input | 1 | Raw demodulator bit, asynchronous |
| fwd_en_i | input | 1 | Forwarding enable; low forces the output high |
| data_o | output | 1 | Debounced, tick-aligned data line |

## Verification
The hardest case to reach is an input change that lands exactly on the tick where the hold window expires. Tick spacing and input toggling must line up for it to happen. The bench gets there by toggling the raw input from a pseudo-random sequence at every clock, under several tick periods, for thousands of cycles. A behavioural model counts ticks since the last edge and is compared against the output on every clock. Directed sequences add spikes placed inside a running window, a disable in the middle of a window, and a single-clock latency probe with a tick on every clock.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Value loaded into the hold counter after an edge. The edge tick itself
  // is tick 0, so MIN_SPACING-1 further ticks must pass before the next edge.
  function automatic int unsigned hold_reload(input int unsigned min_spacing);
    return min_spacing - 1;
  endfunction

  // Width of a counter that can hold the reload value.
  function automatic int unsigned hold_width(input int unsigned min_spacing);
    return (min_spacing <= 2) ? 1 : $clog2(min_spacing);
  endfunction

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= INIT;
    else        chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= INIT;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/guard_hold_timer.sv
module guard_hold_timer
  import guard_pkg::*;
#(
  parameter int unsigned MIN_SPACING = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic load_i,
  output logic idle_o
);
  localparam int unsigned CW     = hold_width(MIN_SPACING);
  localparam logic [CW-1:0] RELOAD = CW'(hold_reload(MIN_SPACING));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (load_i)                 cnt_q <= RELOAD;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/demod_edge_guard.sv
module demod_edge_guard
  import guard_pkg::*;
#(
  parameter int unsigned MIN_SPACING = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  input  logic fwd_en_i,
  output logic data_o
);
  localparam logic IDLE_LEVEL = 1'b1;

  logic sync_bit;
  logic hold_idle;
  logic edge_fire;
  logic data_q;

  guard_sync #(.STAGES(SYNC_STAGES), .INIT(IDLE_LEVEL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_i),
    .q_o   (sync_bit)
  );

  guard_hold_timer #(.MIN_SPACING(MIN_SPACING)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!fwd_en_i),
    .tick_i (tick_i),
    .load_i (edge_fire),
    .idle_o (hold_idle)
  );

  // An edge is taken on a tick with the hold window expired and a mismatch.
  assign edge_fire = fwd_en_i && tick_i && hold_idle && (sync_bit != data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= IDLE_LEVEL;
    else if (!fwd_en_i) data_q <= IDLE_LEVEL;
    else if (edge_fire) data_q <= sync_bit;
  end

  assign data_o = data_q;
endmodule

// File: rtl/demod_edge_guard_chk.sv
module demod_edge_guard_chk #(
  parameter int unsigned MIN_SPACING = 10
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic fwd_en_i,
  input logic data_o,
  input logic edge_fire,
  input logic hold_idle,
  input logic sync_bit
);
  // Ticks since the last edge, saturating; starts saturated (no window).
  int unsigned gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap_q <= MIN_SPACING;
    else if (!fwd_en_i)     gap_q <= MIN_SPACING;
    else if (edge_fire)     gap_q <= 0;
    else if (tick_i && gap_q < MIN_SPACING) gap_q <= gap_q + 1;
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> data_o);

  assert_tick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && fwd_en_i) |=> $stable(data_o));

  // The edge tick itself adds one to the count of ticks passed.
  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fire |-> (gap_q + 1 >= MIN_SPACING));

  assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en_i && tick_i && hold_idle && (sync_bit != data_o)) |=> (data_o == $past(sync_bit)));

  assert_forced_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en_i |=> data_o);
endmodule

bind demod_edge_guard demod_edge_guard_chk #(.MIN_SPACING(MIN_SPACING)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .fwd_en_i  (fwd_en_i),
  .data_o    (data_o),
  .edge_fire (edge_fire),
  .hold_idle (hold_idle),
  .sync_bit  (sync_bit)
);

// File: tb/demod_edge_guard_tb.sv
`timescale 1ns/1ps
module demod_edge_guard_tb;
  localparam int SPACING = 10;
  localparam int BIG     = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic raw_i = 1'b1;
  logic fwd_en_i = 1'b1;
  logic data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  demod_edge_guard u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .raw_i(raw_i), .fwd_en_i(fwd_en_i), .data_o(data_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Tick generator: one strobe every tick_per clocks.
  int tick_per = 1;
  int tick_cnt = 0;
  always @(negedge clk) begin
    if (tick_per <= 1) tick_i <= 1'b1;
    else begin
      tick_cnt = (tick_cnt + 1) % tick_per;
      tick_i <= (tick_cnt == 0);
    end
  end

  // Behavioural reference: raw history queue and a tick distance counter.
  bit hist[$];
  bit m_out = 1'b1;
  int m_gap = BIG;
  bit last_tick, last_fwd;
  int mon_ticks = BIG;   // independent edge-spacing monitor
  int edges_total = 0;
  bit prev_out = 1'b1;

  always @(posedge clk) begin
    last_tick = tick_i;
    last_fwd  = fwd_en_i;
    if (!rst_n) begin
      hist = '{1'b1, 1'b1};
      m_out = 1'b1; m_gap = BIG; mon_ticks = BIG;
    end else begin
      bit samp;
      samp = hist[1];
      if (!fwd_en_i) begin
        m_out = 1'b1; m_gap = BIG; mon_ticks = BIG;
      end else if (tick_i) begin
        if (m_gap < BIG) m_gap++;
        if (mon_ticks < BIG) mon_ticks++;
        if (m_gap >= SPACING && samp != m_out) begin
          m_out = samp; m_gap = 0;
        end
      end
      hist.push_front(raw_i);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare plus edge monitor.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(data_o == m_out, "R4 model compare", data_o, m_out);
      if (data_o != prev_out) begin
        edges_total++;
        if (last_fwd) begin
          check(last_tick, "R2 edge on tick", last_tick, 1);
          check(mon_ticks >= SPACING, "R3 edge spacing", mon_ticks, SPACING);
        end
        mon_ticks = 0;
      end
    end
    prev_out = data_o;
  end

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int e0;
    bit [15:0] lfsr;
    clks(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_o == 1'b1, "R1 reset level", data_o, 1);

    // R4 latency probe with a tick on every clock.
    tick_per = 1;
    clks(20);
    raw_i = 1'b0;            // before edge k
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(data_o == 1'b1, "R4 not yet after k+1", data_o, 1);
    @(negedge clk);
    check(data_o == 1'b0, "R4 follows at k+2", data_o, 0);

    // R5 spike inside the hold window, tick every 2 clocks.
    tick_per = 2;
    clks(40);
    raw_i = 1'b1; clks(30);   // output goes high
    e0 = edges_total;
    raw_i = 1'b0; clks(6);    // edge to low, window starts
    raw_i = 1'b1; clks(2);    // spike
    raw_i = 1'b0; clks(40);
    check(edges_total - e0 == 1, "R5 spike suppressed", edges_total - e0, 1);
    check(data_o == 1'b0, "R5 level kept", data_o, 0);

    // R6 disable mid window, then re-enable with input low.
    raw_i = 1'b1; clks(6);
    fwd_en_i = 1'b0; raw_i = 1'b0;
    clks(3);
    check(data_o == 1'b1, "R6 forced high", data_o, 1);
    fwd_en_i = 1'b1;
    clks(6);
    check(data_o == 1'b0, "R6 first tick after enable", data_o, 0);

    // Pseudo-random toggling under several tick periods.
    lfsr = 16'hACE1;
    for (int p = 1; p <= 8; p = p * 2) begin
      tick_per = p;
      for (int i = 0; i < 3000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        raw_i = (p < 4) ? lfsr[0] : (lfsr[3:0] != 4'd0 ? raw_i : ~raw_i);
        if (i == 1500) fwd_en_i = 1'b0;
        if (i == 1504) fwd_en_i = 1'b1;
        @(negedge clk);
      end
    end
    check(edges_total > 20, "R3 random run produced edges", edges_total, 21);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule